// File: doc/BRIEF.md
# Address Translation Unit with Translation Cache and Access Rights

This block turns a CPU virtual address into a physical address. It first searches a small fully associative translation cache. On a hit it answers in the cycle after the request is taken, with no memory traffic. On a miss it forms the address of a page-table entry from a base-address input and the virtual page number, and reads that entry over a request/response memory port. If the entry can be used, the block installs it in the cache and answers with the translation.

Every request carries an access type: data read, data write or instruction fetch. An entry whose valid bit is clear produces a page-fault status. A valid entry that lacks the right needed for the access produces a protection-fault status. Faulting lookups never enter the cache, so an access retried after software fixes the table reads the entry again. Different virtual pages may share one physical page. A flush input empties the cache, and software asserts it whenever the table base changes.

Top module: `xlate_unit`

## Requirements
- R1: A request that hits the cache gives `rsp_valid` in the cycle after the request handshake, with `rsp_paddr` = {cached physical page number, the untouched 12-bit offset}. No memory request is made.
- R2: On a miss, `mem_req_valid` rises with `mem_req_addr` = `pt_base` + 4 × virtual page number. Address and valid hold steady until `mem_req_ready` is seen.
- R3: A fetched table entry is laid out as bit 0 = valid, bit 1 = write allowed, bit 2 = execute allowed, bits 31:12 = physical page number. When the entry is usable, the response comes in the cycle after `mem_rsp_valid` with status 0 (OK) and address {page number, offset}.
- R4: A fetched entry with bit 0 clear gives status 1 (page fault). It is not cached, so repeating the access reads the table again.
- R5: `req_kind` codes are 0 = read, 1 = write, 2 = fetch. A write to a page without write permission, or a fetch from a page without execute permission, gives status 2 (protection fault), on a hit or a miss. Reads of valid pages never fault. A protection-faulting fetched entry is not cached.
- R6: `req_ready` stays low from the acceptance of a missing request until its response cycle. Each accepted request gets exactly one response.
- R7: The cache holds 16 entries. A new entry goes into the lowest empty slot. When no slot is empty, a round-robin pointer picks the slot; it starts at slot 0 and advances by one after each replacement.
- R8: A high `flush` empties the whole cache by the next cycle and holds `req_ready` low in that cycle, so the next access to any page misses.
- R9: Two virtual pages that map to the same physical page can both be cached and both translate correctly. The cache never holds two entries for one virtual page.
- R10: After reset, `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the translation cache |
| pt_base | input | 32 | Physical base address of the page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| rsp_valid | output | 1 | Response present (one-cycle pulse) |
| rsp_paddr | output | 32 | Physical address, meaningful when status is OK |
| rsp_status | output | 2 | 0 OK, 1 page fault, 2 protection fault |
| mem_req_valid | output | 1 | Table-entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Address of the table entry |
| mem_rsp_valid | input | 1 | Table entry returned |
| mem_rsp_data | input | 32 | Table entry contents |

## Verification
Some properties are checked by assertions on every cycle. A pending table read must keep its address steady. That address must match the base plus the scaled page number. The CPU side must stay not-ready during a read. A page fault may only follow a memory response, and reads must never draw a protection fault. The cache must never hold two matching entries, and a flush must leave no entry valid. Other behaviour can only be shown by the bench's scenarios: hit latency and the absence of memory traffic on hits, refetch after a fault, the victim order once the cache is full, and aliased physical pages.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    localparam int VA_W       = 32;
    localparam int PA_W       = 32;
    localparam int PTE_W      = 32;
    localparam int PAGE_OFF_W = 12;
    localparam int VPN_W      = VA_W - PAGE_OFF_W;
    localparam int PPN_W      = PA_W - PAGE_OFF_W;
    localparam int PTE_V_BIT  = 0;
    localparam int PTE_W_BIT  = 1;
    localparam int PTE_X_BIT  = 2;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        XS_OK         = 2'd0,
        XS_PAGE_FAULT = 2'd1,
        XS_PROT_FAULT = 2'd2
    } xl_status_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             may_write;
        logic             may_exec;
    } map_ent_t;

    function automatic map_ent_t unpack_pte(input logic [PTE_W-1:0] d);
        map_ent_t e;
        e.ppn       = d[PTE_W-1 -: PPN_W];
        e.may_write = d[PTE_W_BIT];
        e.may_exec  = d[PTE_X_BIT];
        return e;
    endfunction

    function automatic xl_status_e rights_check(input acc_kind_e k, input map_ent_t e);
        xl_status_e s;
        s = XS_OK;
        if (k == ACC_WRITE && !e.may_write) s = XS_PROT_FAULT;
        if (k == ACC_FETCH && !e.may_exec)  s = XS_PROT_FAULT;
        return s;
    endfunction

endpackage

// File: rtl/xlate_victim.sv
module xlate_victim #(
    parameter int SLOTS = 16,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SLOTS-1:0] occupied,
    input  logic             advance,
    output logic [IDX_W-1:0] victim_idx
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!occupied[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign victim_idx = free_any ? free_idx : rr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (advance) begin
            rr_q <= (rr_q == IDX_W'(SLOTS - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    // R7: the round-robin pointer only moves when every slot is taken
    assert_rr_only_when_full_R7: assert property (@(posedge clk) disable iff (rst)
        advance |-> (occupied == '1));

endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
    import xlate_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [VPN_W-1:0] lu_vpn,
    output logic             lu_hit,
    output map_ent_t         lu_ent,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  map_ent_t         ins_ent
);
    logic [SLOTS-1:0] vld_q;
    logic [VPN_W-1:0] tag_q [SLOTS];
    map_ent_t         ent_q [SLOTS];
    logic [SLOTS-1:0] match;
    logic [IDX_W-1:0] victim_idx;
    logic             advance;

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (tag_q[g] == lu_vpn);
    end

    always_comb begin
        lu_ent = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (match[i]) lu_ent = ent_q[i];
        end
    end

    assign lu_hit  = |match;
    assign advance = ins_en && !flush && (&vld_q);

    xlate_victim #(.SLOTS(SLOTS)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .occupied   (vld_q),
        .advance    (advance),
        .victim_idx (victim_idx)
    );

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            vld_q <= '0;
        end else if (ins_en) begin
            vld_q[victim_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en && !flush) begin
            tag_q[victim_idx] <= ins_vpn;
            ent_q[victim_idx] <= ins_ent;
        end
    end

    // R9: at most one slot may claim a virtual page
    assert_single_match_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    // R8: a flush leaves no entry valid
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vld_q == '0));

endmodule

// File: rtl/xlate_unit.sv
module xlate_unit
    import xlate_pkg::*;
#(
    parameter int TLB_SLOTS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [PA_W-1:0]  pt_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_status,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data
);
    typedef enum logic [1:0] {S_IDLE, S_PTE_REQ, S_PTE_WAIT} walk_state_e;

    walk_state_e           state_q;
    logic [VPN_W-1:0]      hold_vpn_q;
    logic [PAGE_OFF_W-1:0] hold_off_q;
    acc_kind_e             hold_kind_q;
    logic [PA_W-1:0]       mem_addr_q;
    logic                  rsp_valid_q;
    logic [PA_W-1:0]       rsp_paddr_q;
    xl_status_e            rsp_status_q;

    logic             accept;
    logic [VPN_W-1:0] req_vpn;
    acc_kind_e        req_kind_e;
    logic             lu_hit;
    map_ent_t         lu_ent;
    map_ent_t         fill_ent;
    xl_status_e       fill_status;
    logic             fill_done;
    logic             ins_en;
    logic             unused_pte_bits;

    assign req_vpn    = req_vaddr[VA_W-1:PAGE_OFF_W];
    assign req_kind_e = acc_kind_e'(req_kind);
    assign req_ready  = (state_q == S_IDLE) && !flush;
    assign accept     = req_valid && req_ready;

    assign fill_ent        = unpack_pte(mem_rsp_data);
    assign fill_status     = mem_rsp_data[PTE_V_BIT] ? rights_check(hold_kind_q, fill_ent)
                                                     : XS_PAGE_FAULT;
    assign fill_done       = (state_q == S_PTE_WAIT) && mem_rsp_valid;
    assign ins_en          = fill_done && (fill_status == XS_OK);
    assign unused_pte_bits = ^mem_rsp_data[PAGE_OFF_W-1:PTE_X_BIT+1];

    xlate_tlb #(.SLOTS(TLB_SLOTS)) u_tlb (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .lu_vpn  (req_vpn),
        .lu_hit  (lu_hit),
        .lu_ent  (lu_ent),
        .ins_en  (ins_en),
        .ins_vpn (hold_vpn_q),
        .ins_ent (fill_ent)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            rsp_valid_q  <= 1'b0;
            rsp_paddr_q  <= '0;
            rsp_status_q <= XS_OK;
            hold_vpn_q   <= '0;
            hold_off_q   <= '0;
            hold_kind_q  <= ACC_READ;
            mem_addr_q   <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        hold_vpn_q  <= req_vpn;
                        hold_off_q  <= req_vaddr[PAGE_OFF_W-1:0];
                        hold_kind_q <= req_kind_e;
                        if (lu_hit) begin
                            rsp_valid_q  <= 1'b1;
                            rsp_status_q <= rights_check(req_kind_e, lu_ent);
                            rsp_paddr_q  <= {lu_ent.ppn, req_vaddr[PAGE_OFF_W-1:0]};
                        end else begin
                            mem_addr_q <= pt_base + (PA_W'(req_vpn) << 2);
                            state_q    <= S_PTE_REQ;
                        end
                    end
                end
                S_PTE_REQ: begin
                    if (mem_req_ready) state_q <= S_PTE_WAIT;
                end
                S_PTE_WAIT: begin
                    if (mem_rsp_valid) begin
                        rsp_valid_q  <= 1'b1;
                        rsp_status_q <= fill_status;
                        rsp_paddr_q  <= {fill_ent.ppn, hold_off_q};
                        state_q      <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign mem_req_valid = (state_q == S_PTE_REQ);
    assign mem_req_addr  = mem_addr_q;
    assign rsp_valid     = rsp_valid_q;
    assign rsp_paddr     = rsp_paddr_q;
    assign rsp_status    = rsp_status_q;

    // R2: a pending table read keeps its address until accepted
    assert_mem_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R2: the table read targets base plus scaled page number
    assert_pte_addr_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr == pt_base + (PA_W'(hold_vpn_q) << 2)));

    // R6: the CPU side is closed while a table read is in flight
    assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    // R4: page faults only follow a memory response
    assert_pf_after_fetch_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == XS_PAGE_FAULT) |-> $past(mem_rsp_valid));

    // R5: reads are never refused for rights
    assert_read_no_prot_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == XS_PROT_FAULT) |-> (hold_kind_q != ACC_READ));

    // R3: the page offset passes through unchanged
    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == XS_OK) |-> (rsp_paddr[PAGE_OFF_W-1:0] == hold_off_q));

endmodule

// File: tb/xlate_unit_tb.sv
`timescale 1ns/1ps
module xlate_unit_tb;
    localparam logic [31:0] BASE = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        req_ready, rsp_valid, mem_req_valid;
    logic [31:0] rsp_paddr, mem_req_addr;
    logic [1:0]  rsp_status;

    always #10 clk = ~clk;

    xlate_unit u_dut (
        .clk(clk), .rst(rst), .flush(flush), .pt_base(BASE),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_status(rsp_status), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    typedef struct {
        logic [1:0]  st;
        logic [31:0] paddr;
        bit          hit;
        int          exp_fetch;
        int          acc;
        string       rq;
    } exp_item_t;

    exp_item_t   q[$];
    int          checks = 0, fails = 0;
    int          pcyc = 0, fetch_cnt = 0, exp_fetch = 0, stall = 0;
    int          cur_vpn = 0, pend_vpn = 0;
    bit          pend = 0;
    logic [31:0] pt [64];

    function automatic logic [19:0] ppn_of(input int vpn);
        if (vpn == 8 || vpn == 9) return 20'h12345;
        return 20'hA0000 + 20'(vpn * 7);
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    always @(posedge clk) pcyc++;

    // memory model: ready stalls every third cycle, data one cycle after handshake
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = pt[pend_vpn[5:0]];
            pend = 0;
        end
        stall++;
        mem_req_ready = (stall % 3) != 0;
        if (!rst && mem_req_valid && mem_req_ready) begin
            chk(mem_req_addr == BASE + 32'(cur_vpn * 4), "R2", "pte address",
                mem_req_addr, BASE + 32'(cur_vpn * 4));
            chk(!req_ready, "R6", "ready during fetch", req_ready, 0);
            fetch_cnt++;
            pend_vpn = cur_vpn;
            pend = 1;
        end
    end

    // monitor: pop and compare
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (q.size() == 0) begin
                chk(0, "R6", "unexpected response", 1, 0);
            end else begin
                exp_item_t it;
                it = q.pop_front();
                chk(rsp_status == it.st, it.rq, "status", rsp_status, it.st);
                if (it.st == 2'd0)
                    chk(rsp_paddr == it.paddr, it.rq, "paddr", rsp_paddr, it.paddr);
                if (it.hit)
                    chk(pcyc == it.acc, "R1", "hit latency cycle", pcyc, it.acc);
                chk(fetch_cnt == it.exp_fetch, it.rq, "table reads", fetch_cnt, it.exp_fetch);
            end
        end
    end

    task automatic xlate(input int vpn, input int off, input logic [1:0] kind,
                         input logic [1:0] st, input bit hit, input string rq);
        exp_item_t it;
        @(negedge clk);
        req_vaddr = {ppn_of(0) ^ ppn_of(0) | 20'(vpn), 12'(off)};
        req_kind  = kind;
        req_valid = 1'b1;
        cur_vpn   = vpn;
        while (!req_ready) @(negedge clk);
        if (!hit) exp_fetch++;
        it.st = st;
        it.paddr = {ppn_of(vpn), 12'(off)};
        it.hit = hit;
        it.exp_fetch = exp_fetch;
        it.acc = pcyc + 1;
        it.rq = rq;
        q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) pt[i] = {ppn_of(i), 9'd0, 3'b111};
        pt[5] = {ppn_of(5), 9'd0, 3'b110};
        pt[6] = {ppn_of(6), 9'd0, 3'b001};
        pt[7] = {ppn_of(7), 9'd0, 3'b101};
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10", "req_ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R10", "rsp_valid", rsp_valid, 0);
        chk(mem_req_valid == 1'b0, "R10", "mem_req_valid", mem_req_valid, 0);

        xlate(1, 12'h234, 2'd0, 2'd0, 0, "R3");   // miss, fill
        xlate(1, 12'h010, 2'd1, 2'd0, 1, "R1");   // hit, no table read
        xlate(1, 12'hFFF, 2'd2, 2'd0, 1, "R1");
        xlate(5, 12'h000, 2'd0, 2'd1, 0, "R4");   // invalid entry
        xlate(5, 12'h004, 2'd0, 2'd1, 0, "R4");   // refetched
        xlate(6, 12'h100, 2'd1, 2'd2, 0, "R5");   // write, no W, miss
        xlate(6, 12'h100, 2'd0, 2'd0, 0, "R5");   // not cached: read misses
        xlate(6, 12'h104, 2'd1, 2'd2, 1, "R5");   // write on cached read-only
        xlate(6, 12'h108, 2'd2, 2'd2, 1, "R5");   // fetch without X
        xlate(7, 12'h020, 2'd2, 2'd0, 0, "R5");
        xlate(7, 12'h024, 2'd1, 2'd2, 1, "R5");
        xlate(8, 12'h0AB, 2'd0, 2'd0, 0, "R9");   // aliases
        xlate(9, 12'h0CD, 2'd0, 2'd0, 0, "R9");
        xlate(8, 12'h0EF, 2'd0, 2'd0, 1, "R9");
        xlate(9, 12'h001, 2'd1, 2'd0, 1, "R9");

        // R8 flush
        @(negedge clk);
        flush = 1'b1;
        #1 chk(req_ready == 1'b0, "R8", "ready during flush", req_ready, 0);
        @(negedge clk);
        flush = 1'b0;
        xlate(1, 12'h234, 2'd0, 2'd0, 0, "R8");
        xlate(8, 12'h000, 2'd0, 2'd0, 0, "R8");

        // R7 replacement: refill after flush, then overflow
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int v = 16; v < 32; v++) xlate(v, 12'h040, 2'd0, 2'd0, 0, "R7");
        for (int v = 16; v < 32; v++) xlate(v, 12'h080, 2'd1, 2'd0, 1, "R7");
        xlate(32, 12'h0C0, 2'd0, 2'd0, 0, "R7");  // evicts slot 0 (vpn 16)
        xlate(17, 12'h0C4, 2'd0, 2'd0, 1, "R7");
        xlate(16, 12'h0C8, 2'd0, 2'd0, 0, "R7");  // evicts slot 1 (vpn 17)
        xlate(18, 12'h0CC, 2'd0, 2'd0, 1, "R7");
        xlate(17, 12'h0D0, 2'd0, 2'd0, 0, "R7");  // evicts slot 2 (vpn 18)
        xlate(32, 12'h0D4, 2'd2, 2'd0, 1, "R7");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        if (pcyc > 50000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", pcyc, 50000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule